// File: doc/BRIEF.md
# FIFO Condition Monitor with Sticky Events and Interrupt

This block sits beside a FIFO and watches its fill level together with the write-request and read-request strobes. From these it produces six conditions: empty, full, almost-empty, almost-full, overflow and underflow. Each condition appears in two forms. The live status form shows what the FIFO looked like at the last clock edge. The event form is sticky: once a condition is seen, its event bit stays set until software writes a one to that bit to clear it.

Software reaches the block through a small register bus. It can read the status, read and clear the events, and read and write an interrupt-enable mask. An event bit that goes from 0 to 1 while its enable is set marks that condition as pending. The interrupt line is high while any condition is pending. A pending mark clears when its event bit is cleared.

The mask has a seventh bit that enables all six conditions at once. Read backpressure is assumed to be off, so a read of an empty FIFO is reported as underflow.

Top module: `fifo_evt_irq`

## Requirements
- R1: While reset is asserted, the status, event and enable registers all read 0 and `irq` is 0.
- R2: All three registers use the same bit order: 0 empty, 1 full, 2 almost-empty, 3 almost-full, 4 overflow, 5 underflow. Empty holds when the fill level is 0. Full holds when the fill level equals DEPTH. After each clock edge, status shows the conditions that held at that edge.
- R3: Almost-full holds only when the fill level is strictly above the almost-full threshold. Almost-empty holds only when the fill level is strictly below the almost-empty threshold.
- R4: When `wr_req` is high at an edge while the FIFO is full, status bit 4 is 1 for the following cycle only.
- R5: When `rd_req` is high at an edge while the FIFO is empty, status bit 5 is 1 for the following cycle only. A read of a non-empty FIFO does not set bit 5.
- R6: An event bit becomes 1 at the same edge as its status bit. It stays 1 until a bus write to offset 1 carries a 1 in that bit position. A 0 in the written data leaves the bit unchanged.
- R7: If a condition and a clearing write hit the same event bit at the same edge, the event bit stays 1.
- R8: A condition becomes pending only when its event bit goes from 0 to 1 while its enable bit is 1. Enabling a bit whose event is already set does not raise `irq`.
- R9: Enable bit 6 set to 1 enables all six conditions, whatever the value of enable bits 0 to 5.
- R10: `irq` is high while any condition is pending. A pending condition clears at the edge where its event bit is cleared.
- R11: Register map: offset 0 is status and is read-only, so writes to it are ignored. Offset 1 is the event register. Offset 2 is the 7-bit enable register, read/write, and data bits above bit 6 are dropped. Offset 3 reads 0. `reg_rdata` follows `reg_addr` without a clock.
- R12: After reset is released with the FIFO empty, event bit 0 becomes 1 and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fill_lvl | input | LVL_W | Current number of words in the FIFO |
| wr_req | input | 1 | Write-request strobe seen by the FIFO |
| rd_req | input | 1 | Read-request strobe seen by the FIFO |
| afull_thr | input | LVL_W | Almost-full threshold |
| aempty_thr | input | LVL_W | Almost-empty threshold |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request, high while any condition is pending |

## Verification
Two functions can land on the same event bit at one edge: a clearing write from software and the hardware setting that bit. The bench provokes this in two ways. It holds the fill level at 0 while writing a one to the empty event bit. It also pulses `rd_req` on an empty FIFO in the same cycle as a write that clears the underflow event bit. In both cases the bit must read 1 afterwards. A separate case enables an interrupt only after its event is already set, and `irq` must stay low, which shows the request depends on the 0-to-1 transition and not on the level.

// File: rtl/fie_pkg.sv
package fie_pkg;
  localparam int NCOND     = 6;
  localparam int B_EMPTY   = 0;
  localparam int B_FULL    = 1;
  localparam int B_AEMPTY  = 2;
  localparam int B_AFULL   = 3;
  localparam int B_OVER    = 4;
  localparam int B_UNDER   = 5;
  localparam int IE_GLOBAL = 6;
  localparam int IE_W      = NCOND + 1;

  typedef logic [NCOND-1:0] cond_t;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_EVENT  = 2'd1,
    SEL_IE     = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fie_cond.sv
module fie_cond
  import fie_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] fill_lvl,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic [LVL_W-1:0] afull_thr,
  input  logic [LVL_W-1:0] aempty_thr,
  output cond_t            cond
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic is_empty;
  logic is_full;

  always_comb begin
    is_empty         = (fill_lvl == '0);
    is_full          = (fill_lvl == FULL_LVL);
    cond             = '0;
    cond[B_EMPTY]    = is_empty;
    cond[B_FULL]     = is_full;
    cond[B_AEMPTY]   = (fill_lvl < aempty_thr);
    cond[B_AFULL]    = (fill_lvl > afull_thr);
    cond[B_OVER]     = wr_req & is_full;
    cond[B_UNDER]    = rd_req & is_empty;
  end
endmodule

// File: rtl/fie_sticky.sv
module fie_sticky
  import fie_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cond_t cond,
  input  cond_t clr,
  input  cond_t en,
  output cond_t ev_q,
  output cond_t pend_q
);
  for (genvar i = 0; i < NCOND; i++) begin : g_bit
    logic ev_r, ev_d;
    logic pd_r, pd_d;

    always_comb begin
      // set has priority over a same-cycle clear
      ev_d = (ev_r & ~clr[i]) | cond[i];
      // pending survives only while its event bit survives
      pd_d = (pd_r & ev_d) | (cond[i] & ~ev_r & en[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_r <= 1'b0;
        pd_r <= 1'b0;
      end else begin
        ev_r <= ev_d;
        pd_r <= pd_d;
      end
    end

    assign ev_q[i]   = ev_r;
    assign pend_q[i] = pd_r;
  end
endmodule

// File: rtl/fie_regs.sv
module fie_regs
  import fie_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  cond_t             status_q,
  input  cond_t             ev_q,
  output cond_t             clr,
  output cond_t             en_eff,
  output logic [DATA_W-1:0] reg_rdata
);
  reg_sel_e          sel;
  logic [IE_W-1:0]   ie_q, ie_d;
  logic              ie_we;

  always_comb begin
    sel    = reg_sel_e'(reg_addr);
    ie_we  = reg_wr && (sel == SEL_IE);
    ie_d   = reg_wdata[IE_W-1:0];
    clr    = (reg_wr && (sel == SEL_EVENT)) ? reg_wdata[NCOND-1:0] : '0;
    en_eff = ie_q[IE_GLOBAL] ? '1 : ie_q[NCOND-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
    end else if (ie_we) begin
      ie_q <= ie_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: reg_rdata = DATA_W'(status_q);
      SEL_EVENT:  reg_rdata = DATA_W'(ev_q);
      SEL_IE:     reg_rdata = DATA_W'(ie_q);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fifo_evt_irq.sv
module fifo_evt_irq
  import fie_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  fill_lvl,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [LVL_W-1:0]  afull_thr,
  input  logic [LVL_W-1:0]  aempty_thr,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic  rst_meta, rst_sync_n;
  cond_t cond, status_q, ev_q, pend_q, clr, en_eff;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fie_cond #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cond (
    .fill_lvl  (fill_lvl),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .afull_thr (afull_thr),
    .aempty_thr(aempty_thr),
    .cond      (cond)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) status_q <= '0;
    else             status_q <= cond;
  end

  fie_sticky u_sticky (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cond  (cond),
    .clr   (clr),
    .en    (en_eff),
    .ev_q  (ev_q),
    .pend_q(pend_q)
  );

  fie_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .status_q (status_q),
    .ev_q     (ev_q),
    .clr      (clr),
    .en_eff   (en_eff),
    .reg_rdata(reg_rdata)
  );

  assign irq = |pend_q;
endmodule

// File: rtl/fie_chk.sv
module fie_chk
  import fie_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LVL_W-1:0]  fill_lvl,
  input logic              wr_req,
  input logic              rd_req,
  input logic [1:0]        reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input cond_t             cond,
  input cond_t             status_q,
  input cond_t             ev_q,
  input cond_t             pend_q,
  input logic              irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  a_r2_empty_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_lvl == '0) |=> status_q[B_EMPTY]);

  a_r4_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && fill_lvl == FULL_LVL) |=> status_q[B_OVER]);

  a_r5_underflow_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && fill_lvl == '0) |=> !status_q[B_UNDER]);

  a_r6_status_in_event: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~ev_q) == '0);

  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=>
      ((ev_q & $past(reg_wdata[NCOND-1:0] & ~cond)) == '0));

  a_r10_pend_in_event: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~ev_q) == '0);

  a_r8_irq_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((ev_q & ~$past(ev_q)) != '0));
endmodule

bind fifo_evt_irq fie_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .fill_lvl (fill_lvl),
  .wr_req   (wr_req),
  .rd_req   (rd_req),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_wdata(reg_wdata),
  .cond     (cond),
  .status_q (status_q),
  .ev_q     (ev_q),
  .pend_q   (pend_q),
  .irq      (irq)
);

// File: tb/sim_fifo_evt_irq.sv
`timescale 1ns/1ps
module sim_fifo_evt_irq;
  localparam int DEPTH  = 16;
  localparam int LVL_W  = $clog2(DEPTH + 1);
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [LVL_W-1:0]  fill_lvl;
  logic              wr_req, rd_req;
  logic [LVL_W-1:0]  afull_thr, aempty_thr;
  logic [1:0]        reg_addr;
  logic              reg_wr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fifo_evt_irq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
    .clk, .rst_n, .fill_lvl, .wr_req, .rd_req, .afull_thr, .aempty_thr,
    .reg_addr, .reg_wr, .reg_wdata, .reg_rdata, .irq
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    cyc();
    reg_wr    = 1'b0;
  endtask

  task automatic neutral();
    wr_req   = 1'b0;
    rd_req   = 1'b0;
    fill_lvl = LVL_W'(5);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h3F);
  endtask

  task automatic t_reset();
    int v;
    rst_n = 1'b0;
    fill_lvl = '0;
    cyc(3);
    rd(2'd0, v); chk("R1 status", v, 0);
    rd(2'd1, v); chk("R1 event", v, 0);
    rd(2'd2, v); chk("R1 enable", v, 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    cyc(4);
    rd(2'd1, v); chk("R12 empty event after reset", v, 'h05);
    rd(2'd0, v); chk("R2 status empty", v, 'h05);
    chk("R12 irq stays low", int'(irq), 0);
  endtask

  task automatic t_thresholds();
    int v;
    neutral();
    fill_lvl = LVL_W'(12); cyc();
    rd(2'd0, v); chk("R3 level equal almost-full threshold", v, 0);
    fill_lvl = LVL_W'(13); cyc();
    rd(2'd0, v); chk("R3 level above almost-full threshold", v, 'h08);
    rd(2'd1, v); chk("R6 event set with status", v, 'h08);
    fill_lvl = LVL_W'(3); cyc();
    rd(2'd0, v); chk("R3 level equal almost-empty threshold", v, 0);
    rd(2'd1, v); chk("R6 event stays set", v, 'h08);
    fill_lvl = LVL_W'(2); cyc();
    rd(2'd0, v); chk("R3 level below almost-empty threshold", v, 'h04);
    fill_lvl = LVL_W'(16); cyc();
    rd(2'd0, v); chk("R2 full status", v, 'h0A);
  endtask

  task automatic t_overflow();
    int v;
    neutral();
    fill_lvl = LVL_W'(15); wr_req = 1'b1; cyc(); wr_req = 1'b0;
    rd(2'd0, v); chk("R4 write below full no overflow", v, 'h08);
    fill_lvl = LVL_W'(16); cyc();
    wr_req = 1'b1; cyc(); wr_req = 1'b0;
    rd(2'd0, v); chk("R4 overflow flagged", v, 'h1A);
    cyc();
    rd(2'd0, v); chk("R4 overflow lasts one cycle", v, 'h0A);
    rd(2'd1, v); chk("R6 overflow event sticky", v, 'h1A);
  endtask

  task automatic t_underflow();
    int v;
    neutral();
    rd_req = 1'b1; cyc(); rd_req = 1'b0;
    rd(2'd0, v); chk("R5 read of non-empty fifo", v, 0);
    fill_lvl = '0; cyc();
    rd_req = 1'b1; cyc(); rd_req = 1'b0;
    rd(2'd0, v); chk("R5 underflow flagged", v, 'h25);
    cyc();
    rd(2'd0, v); chk("R5 underflow lasts one cycle", v, 'h05);
  endtask

  task automatic t_w1c();
    int v;
    neutral();
    fill_lvl = LVL_W'(13); cyc();
    fill_lvl = LVL_W'(5);  cyc();
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R6 writing zero leaves event", v, 'h08);
    wr(2'd1, 8'h08);
    rd(2'd1, v); chk("R6 writing one clears event", v, 0);
  endtask

  task automatic t_set_wins();
    int v;
    neutral();
    fill_lvl = '0; cyc();
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R7 empty set beats clear", v & 'h01, 'h01);
    rd_req = 1'b1;
    wr(2'd1, 8'h20);
    rd_req = 1'b0;
    rd(2'd1, v); chk("R7 underflow set beats clear", v & 'h20, 'h20);
  endtask

  task automatic t_irq();
    int v;
    neutral();
    wr(2'd2, 8'h10);
    fill_lvl = LVL_W'(16); cyc();
    chk("R8 disabled conditions give no irq", int'(irq), 0);
    wr_req = 1'b1; cyc(); wr_req = 1'b0;
    chk("R8 enabled overflow raises irq", int'(irq), 1);
    cyc(2);
    chk("R10 irq held while pending", int'(irq), 1);
    wr(2'd1, 8'h10);
    chk("R10 clear event drops irq", int'(irq), 0);
  endtask

  task automatic t_late_enable();
    neutral();
    fill_lvl = '0; rd_req = 1'b1; cyc(); rd_req = 1'b0;
    fill_lvl = LVL_W'(5); cyc();
    chk("R8 underflow masked", int'(irq), 0);
    wr(2'd2, 8'h20);
    cyc();
    chk("R8 late enable gives no irq", int'(irq), 0);
  endtask

  task automatic t_global();
    neutral();
    wr(2'd2, 8'h40);
    fill_lvl = LVL_W'(13); cyc();
    chk("R9 global enable raises irq", int'(irq), 1);
    fill_lvl = LVL_W'(5); cyc();
    wr(2'd1, 8'h08);
    chk("R10 irq clears with event", int'(irq), 0);
  endtask

  task automatic t_regmap();
    int v;
    neutral();
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R11 enable is seven bits", v, 'h7F);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R11 status write ignored", v, 0);
    rd(2'd1, v); chk("R11 status write leaves events", v, 0);
    rd(2'd3, v); chk("R11 unused offset reads zero", v, 0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          fails++;
          $display("FAIL watchdog expired");
          $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
          $finish;
        end
      end
    join_none
  end

  initial begin
    wr_req = 1'b0; rd_req = 1'b0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    afull_thr = LVL_W'(12); aempty_thr = LVL_W'(3);
    fill_lvl = '0;
    t_reset();
    t_thresholds();
    t_overflow();
    t_underflow();
    t_w1c();
    t_set_wins();
    t_irq();
    t_late_enable();
    t_global();
    t_regmap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule